// File: doc/BRIEF.md
# Lane Cluster Packet Builder

This block sits on a single time-sorted data lane and folds individual pixel hits into cluster packets. Each packet covers one 2x2 pixel area in one crossing and collects between one and four hits, each with a small energy value. An incoming hit is compared against every packet that is still open. If the hit has the same time stamp and lies in the same 2x2 area as an open packet, it joins that packet. If it matches none, it opens a fresh packet in a free slot.

Packets leave in the order they were opened. Because a lane sees only one crossing in sixteen, there are regular cycles with no input. In those cycles the oldest open packet is offered on the output toward the time-stamp compression stage.

When every slot is occupied and a hit needs a new packet, the input is held off. During that stall the oldest packet is offered, so the hit can be taken in the cycle after that packet has gone. Each lane uses its own instance of the block. Both sides use a valid/ready handshake.

Top module: `lane_cluster_builder`

## Requirements
- R1: After reset, with no input, `out_valid` is 0, `in_ready` is 1 and `dup_drop` is 0.
- R2: A hit whose time stamp equals that of an open packet, and whose `row>>1` and `col>>1` equal that packet's base coordinates, joins that packet. No new packet is opened.
- R3: A hit at position p = 2*row[0] + col[0] sets bit p of the packet mask. Its energy is placed in `out_energy[p*E_W +: E_W]`. Positions without a hit read energy 0.
- R4: A hit that differs from every open packet in time stamp or in 2x2 area opens a new packet. That packet has base `row>>1`, `col>>1`, the hit's time stamp and a single mask bit.
- R5: In a cycle in which an input hit is accepted, `out_valid` is 0.
- R6: Packets are offered on the output in the order in which they were opened.
- R7: A non-matching hit that arrives while all SLOTS packets are open sees `in_ready` 0. During that stall the oldest packet is offered. The hit is accepted in the first cycle after that packet has been taken. A matching hit is accepted even when all slots are full.
- R8: A hit that falls on an already occupied position of a matching packet is accepted and dropped. `dup_drop` pulses in that cycle, and the packet's mask and energy are unchanged.
- R9: While `out_valid` is 1 and `out_ready` is 0, the offered packet stays the same in the next cycle in which `out_valid` is 1.
- R10: With no open packet, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Hit present on the lane |
| in_ready | output | 1 | Hit can be taken this cycle |
| in_row | input | ROW_W | Pixel row of the hit |
| in_col | input | COL_W | Pixel column of the hit |
| in_ts | input | TS_W | Time stamp of the hit |
| in_energy | input | E_W | Energy value of the hit |
| out_valid | output | 1 | Packet offered |
| out_ready | input | 1 | Downstream takes the packet |
| out_row | output | ROW_W-1 | Packet base row (row>>1) |
| out_col | output | COL_W-1 | Packet base column (col>>1) |
| out_ts | output | TS_W | Packet time stamp |
| out_mask | output | 4 | Occupancy, bit 2*row[0]+col[0] |
| out_energy | output | 4*E_W | Energy per position, position p at p*E_W |
| dup_drop | output | 1 | Pulse when a duplicate hit is dropped |

## Verification
The assertions check on every cycle that no packet is offered while a hit is being accepted, and that a held-off input always comes with an offered packet and a full set of slots. They also check that an offered but untaken packet stays the same, that duplicates are flagged only on accepted hits, and that the open-packet count moves by one on each open and each release. The scenarios are needed to show the merge key, the mask and energy placement, the oldest-first order across several packets, and that a stalled hit is taken right after the oldest packet leaves.

// File: rtl/lcb_pkg.sv
package lcb_pkg;

  typedef enum logic [2:0] {
    ACT_NONE  = 3'd0,
    ACT_JOIN  = 3'd1,
    ACT_DROP  = 3'd2,
    ACT_OPEN  = 3'd3,
    ACT_STALL = 3'd4,
    ACT_EMIT  = 3'd5
  } lcb_act_e;

  // position inside the 2x2 area: row parity is the upper bit
  function automatic logic [1:0] quad_pos(input logic row_lsb, input logic col_lsb);
    return {row_lsb, col_lsb};
  endfunction

  function automatic logic [3:0] quad_onehot(input logic [1:0] pos);
    return 4'b0001 << pos;
  endfunction

endpackage

// File: rtl/lcb_match.sv
module lcb_match #(
  parameter int SLOTS = 4,
  parameter int KR_W  = 7,
  parameter int KC_W  = 7,
  parameter int TS_W  = 10,
  parameter int IDX_W = 2
) (
  input  logic [SLOTS-1:0]           slot_open,
  input  logic [SLOTS-1:0][KR_W-1:0] slot_row,
  input  logic [SLOTS-1:0][KC_W-1:0] slot_col,
  input  logic [SLOTS-1:0][TS_W-1:0] slot_ts,
  input  logic [KR_W-1:0]            key_row,
  input  logic [KC_W-1:0]            key_col,
  input  logic [TS_W-1:0]            key_ts,
  output logic                       hit,
  output logic [IDX_W-1:0]           hit_idx,
  output logic                       free_any,
  output logic [IDX_W-1:0]           free_idx
);

  logic [SLOTS-1:0] same;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_cmp
      assign same[g] = slot_open[g] && (slot_row[g] == key_row) &&
                       (slot_col[g] == key_col) && (slot_ts[g] == key_ts);
    end
  endgenerate

  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (same[i] && !hit) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!slot_open[i] && !free_any) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/lcb_age_fifo.sv
module lcb_age_fifo #(
  parameter int SLOTS = 4,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic [CNT_W-1:0] count
);

  logic [SLOTS-1:0][IDX_W-1:0] order_q;
  logic [IDX_W-1:0]            wr_q;
  logic [IDX_W-1:0]            rd_q;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_idx = order_q[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      order_q <= '0;
      wr_q    <= '0;
      rd_q    <= '0;
      count   <= '0;
    end else begin
      if (push) begin
        order_q[wr_q] <= push_idx;
        wr_q          <= bump(wr_q);
      end
      if (pop) begin
        rd_q <= bump(rd_q);
      end
      if (push && !pop) begin
        count <= count + 1'b1;
      end else if (pop && !push) begin
        count <= count - 1'b1;
      end
    end
  end

endmodule

// File: rtl/lcb_slot_bank.sv
module lcb_slot_bank #(
  parameter int SLOTS = 4,
  parameter int KR_W  = 7,
  parameter int KC_W  = 7,
  parameter int TS_W  = 10,
  parameter int E_W   = 4,
  parameter int IDX_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        open_we,
  input  logic [IDX_W-1:0]            open_idx,
  input  logic [KR_W-1:0]             new_row,
  input  logic [KC_W-1:0]             new_col,
  input  logic [TS_W-1:0]             new_ts,
  input  logic                        join_we,
  input  logic [IDX_W-1:0]            join_idx,
  input  logic [1:0]                  pos,
  input  logic [E_W-1:0]              energy,
  input  logic                        clr_we,
  input  logic [IDX_W-1:0]            clr_idx,
  output logic [SLOTS-1:0]            slot_open,
  output logic [SLOTS-1:0][KR_W-1:0]  slot_row,
  output logic [SLOTS-1:0][KC_W-1:0]  slot_col,
  output logic [SLOTS-1:0][TS_W-1:0]  slot_ts,
  output logic [SLOTS-1:0][3:0]       slot_mask,
  output logic [SLOTS-1:0][4*E_W-1:0] slot_en
);

  import lcb_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_open <= '0;
      slot_row  <= '0;
      slot_col  <= '0;
      slot_ts   <= '0;
      slot_mask <= '0;
      slot_en   <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (open_we && open_idx == IDX_W'(i)) begin
          slot_open[i] <= 1'b1;
          slot_row[i]  <= new_row;
          slot_col[i]  <= new_col;
          slot_ts[i]   <= new_ts;
          slot_mask[i] <= quad_onehot(pos);
          slot_en[i]   <= (4*E_W)'(energy) << (pos * E_W);
        end else if (join_we && join_idx == IDX_W'(i)) begin
          slot_mask[i] <= slot_mask[i] | quad_onehot(pos);
          slot_en[i][pos*E_W +: E_W] <= energy;
        end
        if (clr_we && clr_idx == IDX_W'(i)) begin
          slot_open[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/lane_cluster_builder.sv
module lane_cluster_builder #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  parameter int TS_W  = 10,
  parameter int E_W   = 4,
  parameter int SLOTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ROW_W-1:0]   in_row,
  input  logic [COL_W-1:0]   in_col,
  input  logic [TS_W-1:0]    in_ts,
  input  logic [E_W-1:0]     in_energy,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ROW_W-2:0]   out_row,
  output logic [COL_W-2:0]   out_col,
  output logic [TS_W-1:0]    out_ts,
  output logic [3:0]         out_mask,
  output logic [4*E_W-1:0]   out_energy,
  output logic               dup_drop
);

  import lcb_pkg::*;

  localparam int KR_W  = ROW_W - 1;
  localparam int KC_W  = COL_W - 1;
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic [SLOTS-1:0]            slot_open;
  logic [SLOTS-1:0][KR_W-1:0]  slot_row;
  logic [SLOTS-1:0][KC_W-1:0]  slot_col;
  logic [SLOTS-1:0][TS_W-1:0]  slot_ts;
  logic [SLOTS-1:0][3:0]       slot_mask;
  logic [SLOTS-1:0][4*E_W-1:0] slot_en;

  logic [KR_W-1:0]  key_row;
  logic [KC_W-1:0]  key_col;
  logic [1:0]       pos;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] head_idx;
  logic [CNT_W-1:0] open_cnt;
  lcb_act_e         act;

  // named events for the checker
  logic ev_alloc;
  logic ev_join;
  logic ev_release;

  assign key_row = in_row[ROW_W-1:1];
  assign key_col = in_col[COL_W-1:1];
  assign pos     = quad_pos(in_row[0], in_col[0]);

  lcb_match #(
    .SLOTS(SLOTS), .KR_W(KR_W), .KC_W(KC_W), .TS_W(TS_W), .IDX_W(IDX_W)
  ) u_match (
    .slot_open (slot_open),
    .slot_row  (slot_row),
    .slot_col  (slot_col),
    .slot_ts   (slot_ts),
    .key_row   (key_row),
    .key_col   (key_col),
    .key_ts    (in_ts),
    .hit       (hit),
    .hit_idx   (hit_idx),
    .free_any  (free_any),
    .free_idx  (free_idx)
  );

  always_comb begin
    act = ACT_NONE;
    if (in_valid) begin
      if (hit) begin
        act = slot_mask[hit_idx][pos] ? ACT_DROP : ACT_JOIN;
      end else begin
        act = free_any ? ACT_OPEN : ACT_STALL;
      end
    end else if (open_cnt != '0) begin
      act = ACT_EMIT;
    end
  end

  assign in_ready   = (act != ACT_STALL);
  assign out_valid  = (act == ACT_STALL) || (act == ACT_EMIT);
  assign dup_drop   = (act == ACT_DROP);
  assign ev_alloc   = (act == ACT_OPEN);
  assign ev_join    = (act == ACT_JOIN);
  assign ev_release = out_valid && out_ready;

  lcb_age_fifo #(
    .SLOTS(SLOTS), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ev_alloc),
    .push_idx (free_idx),
    .pop      (ev_release),
    .head_idx (head_idx),
    .count    (open_cnt)
  );

  lcb_slot_bank #(
    .SLOTS(SLOTS), .KR_W(KR_W), .KC_W(KC_W), .TS_W(TS_W), .E_W(E_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_we   (ev_alloc),
    .open_idx  (free_idx),
    .new_row   (key_row),
    .new_col   (key_col),
    .new_ts    (in_ts),
    .join_we   (ev_join),
    .join_idx  (hit_idx),
    .pos       (pos),
    .energy    (in_energy),
    .clr_we    (ev_release),
    .clr_idx   (head_idx),
    .slot_open (slot_open),
    .slot_row  (slot_row),
    .slot_col  (slot_col),
    .slot_ts   (slot_ts),
    .slot_mask (slot_mask),
    .slot_en   (slot_en)
  );

  assign out_row    = slot_row[head_idx];
  assign out_col    = slot_col[head_idx];
  assign out_ts     = slot_ts[head_idx];
  assign out_mask   = slot_mask[head_idx];
  assign out_energy = slot_en[head_idx];

endmodule

// File: rtl/lcb_checker.sv
module lcb_checker #(
  parameter int SLOTS = 4,
  parameter int CNT_W = 3,
  parameter int TS_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [TS_W-1:0]  out_ts,
  input logic [3:0]       out_mask,
  input logic             dup_drop,
  input logic             ev_alloc,
  input logic             ev_release,
  input logic [CNT_W-1:0] open_cnt
);

  // R5
  accept_blocks_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> !out_valid);

  // R7
  stall_offers_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && open_cnt == CNT_W'(SLOTS)));

  // R9
  held_out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (!out_valid || ($stable(out_ts) && $stable(out_mask))));

  // R8
  dup_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dup_drop |-> (in_valid && in_ready && !ev_alloc));

  // R10
  empty_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open_cnt == '0) |-> !out_valid);

  // R6
  release_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> (open_cnt == CNT_W'($past(open_cnt) - 1'b1)));

  // R4
  alloc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_alloc |=> (open_cnt == CNT_W'($past(open_cnt) + 1'b1)));

endmodule

bind lane_cluster_builder lcb_checker #(
  .SLOTS(SLOTS), .CNT_W(CNT_W), .TS_W(TS_W)
) u_lcb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_ts     (out_ts),
  .out_mask   (out_mask),
  .dup_drop   (dup_drop),
  .ev_alloc   (ev_alloc),
  .ev_release (ev_release),
  .open_cnt   (open_cnt)
);

// File: tb/lane_cluster_builder_test.sv
`timescale 1ns/1ps
module lane_cluster_builder_test;

  localparam int ROW_W = 8;
  localparam int COL_W = 8;
  localparam int TS_W  = 10;
  localparam int E_W   = 4;
  localparam int SLOTS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [ROW_W-1:0] in_row = '0;
  logic [COL_W-1:0] in_col = '0;
  logic [TS_W-1:0]  in_ts = '0;
  logic [E_W-1:0]   in_energy = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [ROW_W-2:0] out_row;
  logic [COL_W-2:0] out_col;
  logic [TS_W-1:0]  out_ts;
  logic [3:0]       out_mask;
  logic [4*E_W-1:0] out_energy;
  logic dup_drop;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_cluster_builder #(
    .ROW_W(ROW_W), .COL_W(COL_W), .TS_W(TS_W), .E_W(E_W), .SLOTS(SLOTS)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_row(in_row), .in_col(in_col), .in_ts(in_ts), .in_energy(in_energy),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_row(out_row), .out_col(out_col), .out_ts(out_ts),
    .out_mask(out_mask), .out_energy(out_energy), .dup_drop(dup_drop)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // position inside the 2x2 area, restated from the requirement text
  function automatic int spot(input int row, input int col);
    return (row % 2) * 2 + (col % 2);
  endfunction

  function automatic logic [15:0] place(input int row, input int col, input int e);
    return 16'(e) << (4 * spot(row, col));
  endfunction

  task automatic send_hit(input int row, input int col, input int ts, input int e, input string req);
    @(negedge clk);
    in_valid  = 1'b1;
    in_row    = ROW_W'(row);
    in_col    = COL_W'(col);
    in_ts     = TS_W'(ts);
    in_energy = E_W'(e);
    #1;
    chk({req, " in_ready"}, 32'(in_ready), 32'd1);
    chk({req, " no out while accepting"}, 32'(out_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_expect(input int brow, input int bcol, input int ts,
                            input int mask, input logic [15:0] en, input string req);
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    #1;
    chk({req, " out_valid"}, 32'(out_valid), 32'd1);
    chk({req, " out_row"}, 32'(out_row), 32'(brow));
    chk({req, " out_col"}, 32'(out_col), 32'(bcol));
    chk({req, " out_ts"}, 32'(out_ts), 32'(ts));
    chk({req, " out_mask"}, 32'(out_mask), 32'(mask));
    chk({req, " out_energy"}, 32'(out_energy), 32'(en));
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk({req, " out_valid idle"}, 32'(out_valid), 32'd0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd1);
    chk("R1 dup_drop", 32'(dup_drop), 32'd0);
    expect_empty("R10");
  endtask

  task automatic t_merge();
    send_hit(10, 20, 5, 3, "R2");
    send_hit(11, 21, 5, 7, "R2");
    send_hit(10, 21, 5, 1, "R3");
    pop_expect(5, 10, 5, 4'b1011,
               place(10, 20, 3) | place(11, 21, 7) | place(10, 21, 1), "R3");
    expect_empty("R10");
  endtask

  task automatic t_split();
    send_hit(4, 4, 1, 1, "R4");
    send_hit(4, 4, 2, 2, "R4");
    send_hit(6, 4, 1, 3, "R4");
    pop_expect(2, 2, 1, 1, 16'h0001, "R6");
    pop_expect(2, 2, 2, 1, 16'h0002, "R6");
    pop_expect(3, 2, 1, 1, 16'h0003, "R6");
    expect_empty("R10");
  endtask

  task automatic t_idle_release();
    @(negedge clk);
    out_ready = 1'b1;
    send_hit(9, 3, 40, 6, "R5");
    #1;
    chk("R5 idle release valid", 32'(out_valid), 32'd1);
    chk("R5 idle release mask", 32'(out_mask), 32'(4'b0001 << spot(9, 3)));
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    expect_empty("R10");
  endtask

  task automatic t_full();
    send_hit(0, 0, 20, 1, "R7");
    send_hit(2, 0, 20, 2, "R7");
    send_hit(4, 0, 20, 3, "R7");
    send_hit(6, 0, 20, 4, "R7");
    @(negedge clk);
    in_valid = 1'b1; in_row = 8; in_col = 0; in_ts = 20; in_energy = 5;
    #1;
    chk("R7 stall in_ready", 32'(in_ready), 32'd0);
    chk("R7 stall out_valid", 32'(out_valid), 32'd1);
    chk("R7 stall oldest row", 32'(out_row), 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R9 held row", 32'(out_row), 32'd0);
    chk("R9 held energy", 32'(out_energy), 32'h0001);
    chk("R9 held in_ready", 32'(in_ready), 32'd0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    chk("R7 taken after release", 32'(in_ready), 32'd1);
    chk("R7 no out on accept", 32'(out_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    send_hit(3, 1, 20, 9, "R7 join when full");
    pop_expect(1, 0, 20, 4'b1001, 16'h9002, "R6");
    pop_expect(2, 0, 20, 1, 16'h0003, "R6");
    pop_expect(3, 0, 20, 1, 16'h0004, "R6");
    pop_expect(4, 0, 20, 1, 16'h0005, "R7");
    expect_empty("R10");
  endtask

  task automatic t_dup();
    send_hit(0, 0, 9, 5, "R8");
    @(negedge clk);
    in_valid = 1'b1; in_row = 0; in_col = 0; in_ts = 9; in_energy = 12;
    #1;
    chk("R8 dup accepted", 32'(in_ready), 32'd1);
    chk("R8 dup_drop", 32'(dup_drop), 32'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk("R8 dup_drop clears", 32'(dup_drop), 32'd0);
    pop_expect(0, 0, 9, 1, 16'h0005, "R8");
    expect_empty("R10");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_merge();
    t_split();
    t_idle_release();
    t_full();
    t_dup();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule